// File: doc/BRIEF.md
# Interrupt Pending and Claim/Complete Unit

This block gathers level-sensitive interrupt lines and holds a pending flag and a claimed flag for each source. Both sets of flags are kept as packed 32-bit words, with source n in word n/32, bit n%32. Source 0 is reserved and means "no interrupt". A core reads the claim register to take the most urgent pending source. It writes that source's ID back to the same register when its handler is done.

While a source is claimed, a fresh assertion on its line cannot set the visible pending flag. The assertion is not dropped, though. It is held in a hidden flag for that source, and when the source is completed it becomes a visible pending request again. If the line deasserts before completion, the hidden flag is cleared first and nothing is raised.

A single register port handles all accesses. It is a request strobe with a write flag, an address, write data and registered read data. Address 0 is the claim/complete register. Addresses 1 to NSRC-1 hold the per-source priorities.

Top module: `irq_claim_unit`

## Requirements
- R1: After reset, every pending, hidden and claimed flag and every priority is zero, `reg_rdata` is 0 and `irq_o` is low.
- R2: A rising edge on the line of an unclaimed source sets its pending flag. `irq_o` is high while any pending, unclaimed source has a nonzero priority.
- R3: A read of address 0 returns, in `reg_rdata` one cycle after the request, the ID of the pending unclaimed source with the highest priority. Ties go to the lowest ID. Sources with priority 0 are never returned, and the read returns 0 when nothing qualifies.
- R4: A claim read that returns a source clears that source's pending flag and sets its claimed flag, so a further claim does not return it.
- R5: While a source is claimed, a new assertion on its line does not set its visible pending flag: `irq_o` stays low and a claim returns 0.
- R6: Completing a claimed source whose line was asserted during the claimed window, and was still asserted or held at completion, makes that source pending again.
- R7: If a line asserted during the claimed window deasserts before completion, the completion releases the source without raising it again.
- R8: A write to address 0 completes the source whose ID is in `reg_wdata`. If that source is not claimed, no pending or claimed flag changes. Every such write clears `reg_rdata` to 0.
- R9: A write to address n (1 to NSRC-1) sets the priority of source n from the low PRIO_W data bits, and a read of address n returns it.
- R10: Sources at or above 32 live in the second word and behave exactly like sources in the first word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_src | input | NSRC | Level interrupt lines; bit 0 is unused |
| reg_valid | input | 1 | Register access strobe, one cycle per access |
| reg_write | input | 1 | 1 = write, 0 = read |
| reg_addr | input | ID_W | 0 = claim/complete, n = priority of source n |
| reg_wdata | input | 32 | Write data (completed ID or priority) |
| reg_rdata | output | 32 | Read data, updated on the edge that takes the request |
| irq_o | output | 1 | Interrupt request to the core |

## Verification
The claim path is exercised with a lone source, with three sources that combine a strict priority winner and an equal-priority pair, and with a source of priority 0. Together these separate the ordering rule, the tie break toward the lower ID and the exclusion of zero-priority sources. The claimed window is tested twice, each time with a line that asserts during the window. In the first case the line is still held at completion, and in the second it has dropped. The two cases show the difference between re-raising a held assertion and discarding a withdrawn one. A completion of an unclaimed, still-pending source shows that such a write changes no flag yet clears the read-back value.

// File: rtl/irq_claim_unit.sv
module irq_claim_unit #(
  parameter int NSRC   = 40,
  parameter int PRIO_W = 3
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NSRC-1:0]            irq_src,
  input  logic                       reg_valid,
  input  logic                       reg_write,
  input  logic [$clog2(NSRC)-1:0]    reg_addr,
  input  logic [31:0]                reg_wdata,
  output logic [31:0]                reg_rdata,
  output logic                       irq_o
);
  localparam int ID_W   = $clog2(NSRC);
  localparam int NWORDS = (NSRC + 31) / 32;
  localparam int NBITS  = NWORDS * 32;

  logic [NWORDS-1:0][31:0] pend_w, hid_w, clm_w;
  logic [NBITS-1:0]        pend, hid, clm;
  logic [NSRC-1:0]         src_q;
  logic [PRIO_W-1:0]       prio [NSRC];
  logic [ID_W-1:0]         best;
  logic [PRIO_W-1:0]       best_p;

  assign pend = pend_w;
  assign hid  = hid_w;
  assign clm  = clm_w;

  wire acc_claim = reg_valid && !reg_write && reg_addr == '0;
  wire acc_done  = reg_valid &&  reg_write && reg_addr == '0;
  wire done_ok   = reg_wdata < 32'(NSRC) && reg_wdata != 32'd0;
  wire [ID_W-1:0] done_id = reg_wdata[ID_W-1:0];

  always_comb begin
    best   = '0;
    best_p = '0;
    for (int n = 1; n < NSRC; n++)
      if (pend[n] && !clm[n] && prio[n] > best_p) begin
        best   = ID_W'(n);
        best_p = prio[n];
      end
  end

  assign irq_o = best != '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_w    <= '0;
      hid_w     <= '0;
      clm_w     <= '0;
      src_q     <= '0;
      reg_rdata <= '0;
      for (int n = 0; n < NSRC; n++) prio[n] <= '0;
    end else begin
      src_q <= irq_src;
      for (int n = 1; n < NSRC; n++) begin
        if (clm[n])
          hid_w[n/32][n%32] <= irq_src[n];
        else if (irq_src[n] && !src_q[n])
          pend_w[n/32][n%32] <= 1'b1;
      end
      if (acc_claim) begin
        reg_rdata <= 32'(best);
        if (best != '0) begin
          pend_w[best/32][best%32] <= 1'b0;
          clm_w[best/32][best%32]  <= 1'b1;
        end
      end else if (acc_done) begin
        reg_rdata <= '0;
        if (done_ok && clm[done_id]) begin
          clm_w[done_id/32][done_id%32] <= 1'b0;
          hid_w[done_id/32][done_id%32] <= 1'b0;
          if (hid[done_id] || irq_src[done_id])
            pend_w[done_id/32][done_id%32] <= 1'b1;
        end
      end else if (reg_valid) begin
        if (reg_write) begin
          if (32'(reg_addr) < 32'(NSRC)) prio[reg_addr] <= reg_wdata[PRIO_W-1:0];
        end else begin
          reg_rdata <= (32'(reg_addr) < 32'(NSRC)) ? 32'(prio[reg_addr]) : 32'd0;
        end
      end
    end
  end

  // R5: a claimed source never shows as visibly pending
  a_r5_no_pend_while_claimed: assert property (@(posedge clk) disable iff (!rst_n)
    (pend & clm) == '0);

  // R7: a held assertion exists only inside a claimed window
  a_r7_hidden_only_claimed: assert property (@(posedge clk) disable iff (!rst_n)
    (hid & ~clm) == '0);

  // R4: a successful claim leaves that source claimed and not pending
  a_r4_claim_marks: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_claim && irq_o) |=> (clm[reg_rdata[ID_W-1:0]] && !pend[reg_rdata[ID_W-1:0]]));

  // R3: with no request outstanding a claim returns 0
  a_r3_empty_claim: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_claim && !irq_o) |=> reg_rdata == 32'd0);

  // R8: a completion clears the read-back value
  a_r8_done_clears: assert property (@(posedge clk) disable iff (!rst_n)
    acc_done |=> reg_rdata == 32'd0);

  // R8: completing an unclaimed source leaves the claimed flags alone
  a_r8_unclaimed_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_done && !(done_ok && clm[done_id])) |=> $stable(clm));
endmodule

// File: tb/irq_claim_unit_bench.sv
module irq_claim_unit_bench;
  localparam int NSRC = 40;
  localparam int ID_W = $clog2(NSRC);

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [NSRC-1:0] irq_src = '0;
  logic            reg_valid = 1'b0;
  logic            reg_write = 1'b0;
  logic [ID_W-1:0] reg_addr = '0;
  logic [31:0]     reg_wdata = '0;
  logic [31:0]     reg_rdata;
  logic            irq_o;
  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  irq_claim_unit #(.NSRC(NSRC), .PRIO_W(3)) u_irq_claim_unit (
    .clk, .rst_n, .irq_src, .reg_valid, .reg_write, .reg_addr,
    .reg_wdata, .reg_rdata, .irq_o);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic access(input logic wr, input int addr, input int data);
    @(negedge clk);
    reg_valid = 1'b1; reg_write = wr; reg_addr = ID_W'(addr); reg_wdata = 32'(data);
    @(negedge clk);
    reg_valid = 1'b0; reg_write = 1'b0;
  endtask

  task automatic claim(output int id);
    access(1'b0, 0, 0);
    id = int'(reg_rdata);
  endtask

  task automatic complete(input int id);
    access(1'b1, 0, id);
  endtask

  task automatic line(input int n, input logic v);
    @(negedge clk);
    irq_src[n] = v;
    @(negedge clk);
  endtask

  task automatic t_reset;
    int id;
    chk("R1 irq_o after reset", 32'(irq_o), 0);
    chk("R1 rdata after reset", reg_rdata, 0);
    access(1'b0, 5, 0);
    chk("R1 priority 5 after reset", reg_rdata, 0);
    claim(id);
    chk("R1 claim after reset", 32'(id), 0);
  endtask

  task automatic t_prio;
    access(1'b1, 3, 2);
    access(1'b1, 7, 2);
    access(1'b1, 35, 5);
    access(1'b0, 7, 0);
    chk("R9 priority 7 readback", reg_rdata, 2);
    access(1'b0, 35, 0);
    chk("R9 priority 35 readback", reg_rdata, 5);
  endtask

  task automatic t_basic;
    int id;
    line(7, 1'b1);
    chk("R2 irq_o after rise", 32'(irq_o), 1);
    claim(id);
    chk("R3 single claim", 32'(id), 7);
    chk("R4 irq_o after claim", 32'(irq_o), 0);
    claim(id);
    chk("R4 second claim", 32'(id), 0);
    line(7, 1'b0);
    complete(7);
    claim(id);
    chk("R7 no reraise after release", 32'(id), 0);
  endtask

  task automatic t_order;
    int id;
    @(negedge clk);
    irq_src[3] = 1'b1; irq_src[7] = 1'b1; irq_src[35] = 1'b1;
    @(negedge clk);
    claim(id);
    chk("R3 R10 highest priority first", 32'(id), 35);
    claim(id);
    chk("R3 tie goes to lower id", 32'(id), 3);
    claim(id);
    chk("R3 remaining source", 32'(id), 7);
    @(negedge clk);
    irq_src[3] = 1'b0; irq_src[7] = 1'b0; irq_src[35] = 1'b0;
    complete(35); complete(3); complete(7);
    claim(id);
    chk("R3 empty after completions", 32'(id), 0);
  endtask

  task automatic t_prio0;
    int id;
    line(9, 1'b1);
    chk("R2 priority 0 keeps irq_o low", 32'(irq_o), 0);
    claim(id);
    chk("R3 priority 0 never claimed", 32'(id), 0);
    line(9, 1'b0);
  endtask

  task automatic t_hidden;
    int id;
    line(35, 1'b1);
    claim(id);
    chk("R10 claim source 35", 32'(id), 35);
    line(35, 1'b0);
    line(35, 1'b1);
    chk("R5 irq_o low while claimed", 32'(irq_o), 0);
    claim(id);
    chk("R5 claim while claimed", 32'(id), 0);
    complete(35);
    chk("R6 irq_o after completion", 32'(irq_o), 1);
    claim(id);
    chk("R6 source raised again", 32'(id), 35);
    line(35, 1'b0);
    complete(35);
    claim(id);
    chk("R7 nothing left", 32'(id), 0);
  endtask

  task automatic t_hidden_drop;
    int id;
    line(7, 1'b1);
    claim(id);
    chk("R3 claim source 7", 32'(id), 7);
    line(7, 1'b0);
    line(7, 1'b1);
    line(7, 1'b0);
    complete(7);
    chk("R7 irq_o stays low", 32'(irq_o), 0);
    claim(id);
    chk("R7 withdrawn assertion dropped", 32'(id), 0);
  endtask

  task automatic t_unclaimed;
    int id;
    line(3, 1'b1);
    access(1'b0, 3, 0);
    chk("R9 priority read before complete", reg_rdata, 2);
    complete(3);
    chk("R8 complete clears rdata", reg_rdata, 0);
    chk("R8 pending kept after stray complete", 32'(irq_o), 1);
    claim(id);
    chk("R8 source still claimable", 32'(id), 3);
    line(3, 1'b0);
    complete(3);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_prio();
    t_basic();
    t_order();
    t_prio0();
    t_hidden();
    t_hidden_drop();
    t_unclaimed();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule